// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is a memory-mapped I2C controller that moves exactly one byte for each software command. Software loads the data buffer and then writes the control register with the transfer bit and the enable bit set. The block then does one of three things. It can send a START followed by the buffer as an address byte, whose bit 0 fixes the direction. It can shift the buffer out as a data byte. It can clock a byte in from the target. Any of these can end with a STOP. Completion is reported through sticky status flags and a single interrupt line that is gated by per-flag enables.

SCL and SDA are open-drain. The block only pulls each line low, through `scl_oe` and `sda_oe`, and reads the wired level back on `scl_i` and `sda_i`. A divider sets the length of every half bit to `HALF_PERIOD` clock cycles. SDA is updated one cycle after SCL, so a data change never coincides with an SCL edge.

The bit engine is a state machine with these states:
- `E_IDLE`: SCL is held low while a transaction is open and released otherwise.
- `E_RS_HI`: both lines are released before a repeated START.
- `E_START`: SDA falls while SCL is high.
- `E_BIT_LO` and `E_BIT_HI`: the two half periods of each of eight data bits.
- `E_ACK_LO` and `E_ACK_HI`: the acknowledge bit.
- `E_STOP_LO`, `E_STOP_HI` and `E_STOP_END`: the STOP sequence.

The transitions are as follows:
- A command in `E_IDLE` goes to `E_START` on an idle bus, to `E_RS_HI` when a transaction is open and START is requested, and to `E_BIT_LO` otherwise.
- An abort while a transaction is open goes to `E_STOP_LO`.
- The remaining transitions happen on a divider tick. They step `E_RS_HI` to `E_START`, `E_START` to `E_BIT_LO`, and `E_BIT_LO` to `E_BIT_HI`.
- `E_BIT_HI` returns to `E_BIT_LO` until the eighth bit, then goes to `E_ACK_LO`. `E_ACK_LO` goes to `E_ACK_HI`.
- `E_ACK_HI` goes to `E_STOP_LO` when STOP was requested and to `E_IDLE` otherwise.
- The STOP sequence runs `E_STOP_LO`, `E_STOP_HI`, `E_STOP_END` and back to `E_IDLE`.

Top module: `i2c_byte_master`

## Requirements
- R1: Registers decode at byte offsets 0x80 (bus monitor), 0x88 (data buffer), 0x90 (control), 0x98 (status) and 0xA0 (own address); a read of any other offset returns 0.
- R2: Control bits are 0 START, 1 STOP, 2 NACK-on-receive, 3 transfer, 4 abort, 6 enable, 8 transmit-empty IE, 9 receive-full IE and 10 bus-error IE; a control write stores all bits except bit 3, which always reads 0.
- R3: A control write with bits 3 and 6 set and bit 0 set sends a START, or a repeated START when a transaction is open, followed by the data buffer MSB first as the address byte; buffer bit 0 is copied to status bit 0 (1 = read).
- R4: With bit 0 clear, status bit 0 selects the direction: 0 shifts the buffer out MSB first, 1 clocks a byte into the buffer MSB first and answers NACK if control bit 2 is set, ACK otherwise.
- R5: Control bit 1 appends a STOP (SDA rising while SCL is high) after the byte; status bit 2 reads 1 from a START until the STOP and SCL/SDA are both released when it is 0.
- R6: On an acknowledged address or transmitted byte status bit 6 is set, on a received byte status bit 7 is set, and in both cases status bit 1 is cleared; flags are set only when a byte finishes.
- R7: When the target leaves SDA high in the acknowledge slot, status bits 6, 10 and 1 are set together.
- R8: Writing the status register clears the bits set in both the written value and 0x07F0; bits 0 and 1 are not affected.
- R9: `irq_o` is (status10 AND control10) OR (status7 AND control9) OR (status6 AND control8) OR status9.
- R10: A control write with bit 3 clear and bits 6 and 4 set generates a STOP when a transaction is open, after which status bit 2 reads 0; it sets no flag.
- R11: Data buffer writes keep bits 7:0 and own-address writes keep bits 6:0; the other read bits are 0.
- R12: A control write while a byte or STOP is in progress is ignored: control is not updated and no command or abort is taken.
- R13: The bus monitor reads the SCL line in bit 1 and SDA in bit 0; after reset both lines are released, and control, status and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A wrong engine state shows on the wire within one half bit. Examples are a missing START or STOP, a bit count that is off by one, or a repeated START issued as a plain START. The target model in the bench then captures a different byte or counts the wrong number of START and STOP conditions by the end of that byte. A wrong direction latch or a wrong acknowledge decision shows at the next status read after the byte, as the wrong choice among bits 6, 7, 10 and 1, or as a data buffer that was overwritten or left unchanged when it should not have been. Errors in the interrupt gating and in the write-1-to-clear mask appear on `irq_o` or in the status read in the cycle after the offending register write.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam logic [7:0] OFS_MON = 8'h80;
    localparam logic [7:0] OFS_BUF = 8'h88;
    localparam logic [7:0] OFS_CTL = 8'h90;
    localparam logic [7:0] OFS_STS = 8'h98;
    localparam logic [7:0] OFS_OWN = 8'hA0;

    localparam int C_START = 0;
    localparam int C_STOP  = 1;
    localparam int C_NACK  = 2;
    localparam int C_XFER  = 3;
    localparam int C_ABORT = 4;
    localparam int C_EN    = 6;
    localparam int C_TEIE  = 8;
    localparam int C_RFIE  = 9;
    localparam int C_BEIE  = 10;

    localparam int S_RW   = 0;
    localparam int S_ACK  = 1;
    localparam int S_BUSY = 2;
    localparam int S_TE   = 6;
    localparam int S_RF   = 7;
    localparam int S_SLV  = 9;
    localparam int S_BE   = 10;

    localparam logic [15:0] CTL_KEEP = 16'hFFF7;
    localparam logic [15:0] STS_W1C  = 16'h07F0;

    typedef enum logic [3:0] {
        E_IDLE, E_RS_HI, E_START, E_BIT_LO, E_BIT_HI,
        E_ACK_LO, E_ACK_HI, E_STOP_LO, E_STOP_HI, E_STOP_END
    } eng_state_t;

    typedef struct packed {
        logic       start;
        logic       stop;
        logic       rx;
        logic       nack;
        logic [7:0] tx_byte;
    } byte_cmd_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int unsigned HALF_PERIOD = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int unsigned HALF_PERIOD = 625
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  byte_cmd_t  cmd,
    input  logic       abort,
    input  logic       sda_i,
    output logic       scl_low,
    output logic       sda_low,
    output logic       active,
    output logic       held,
    output logic       done,
    output logic       ack_ok,
    output logic [7:0] rx_data
);
    localparam int unsigned NBITS = 8;
    localparam logic [2:0] TOPBIT = 3'(NBITS - 1);

    eng_state_t state_q, state_nx;
    byte_cmd_t  cmd_q;
    logic [7:0] shreg_q;
    logic [2:0] bitcnt_q;
    logic       from_cmd_q;
    logic       sda_nx;
    logic       tick;

    i2cm_tick #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q != E_IDLE),
        .tick (tick)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            E_IDLE: begin
                if (go) begin
                    if (cmd.start) state_nx = held ? E_RS_HI : E_START;
                    else           state_nx = E_BIT_LO;
                end else if (abort && held) begin
                    state_nx = E_STOP_LO;
                end
            end
            E_RS_HI:    if (tick) state_nx = E_START;
            E_START:    if (tick) state_nx = E_BIT_LO;
            E_BIT_LO:   if (tick) state_nx = E_BIT_HI;
            E_BIT_HI:   if (tick) state_nx = (bitcnt_q == 3'd0) ? E_ACK_LO : E_BIT_LO;
            E_ACK_LO:   if (tick) state_nx = E_ACK_HI;
            E_ACK_HI:   if (tick) state_nx = cmd_q.stop ? E_STOP_LO : E_IDLE;
            E_STOP_LO:  if (tick) state_nx = E_STOP_HI;
            E_STOP_HI:  if (tick) state_nx = E_STOP_END;
            E_STOP_END: if (tick) state_nx = E_IDLE;
            default:    state_nx = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= E_IDLE;
            cmd_q      <= '0;
            shreg_q    <= '0;
            bitcnt_q   <= '0;
            from_cmd_q <= 1'b0;
            held       <= 1'b0;
            done       <= 1'b0;
            ack_ok     <= 1'b0;
            sda_low    <= 1'b0;
        end else begin
            state_q <= state_nx;
            sda_low <= sda_nx;
            done    <= 1'b0;
            unique case (state_q)
                E_IDLE: begin
                    if (go) begin
                        cmd_q      <= cmd;
                        shreg_q    <= cmd.tx_byte;
                        bitcnt_q   <= TOPBIT;
                        from_cmd_q <= 1'b1;
                        if (cmd.start) held <= 1'b1;
                    end else if (abort && held) begin
                        from_cmd_q <= 1'b0;
                    end
                end
                E_BIT_HI: begin
                    if (tick) begin
                        shreg_q <= {shreg_q[6:0], sda_i};
                        if (bitcnt_q != 3'd0) bitcnt_q <= bitcnt_q - 1'b1;
                    end
                end
                E_ACK_HI: begin
                    if (tick) begin
                        ack_ok <= cmd_q.rx | ~sda_i;
                        if (!cmd_q.stop) done <= 1'b1;
                    end
                end
                E_STOP_END: begin
                    if (tick) begin
                        held <= 1'b0;
                        done <= from_cmd_q;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        scl_low = 1'b0;
        sda_nx  = 1'b0;
        unique case (state_q)
            E_IDLE:     scl_low = held;
            E_RS_HI:    scl_low = 1'b0;
            E_START:    sda_nx  = 1'b1;
            E_BIT_LO: begin
                scl_low = 1'b1;
                sda_nx  = !cmd_q.rx && !shreg_q[7];
            end
            E_BIT_HI:   sda_nx  = !cmd_q.rx && !shreg_q[7];
            E_ACK_LO: begin
                scl_low = 1'b1;
                sda_nx  = cmd_q.rx && !cmd_q.nack;
            end
            E_ACK_HI:   sda_nx  = cmd_q.rx && !cmd_q.nack;
            E_STOP_LO: begin
                scl_low = 1'b1;
                sda_nx  = 1'b1;
            end
            E_STOP_HI:  sda_nx  = 1'b1;
            E_STOP_END: sda_nx  = 1'b0;
            default: ;
        endcase
    end

    assign active  = (state_q != E_IDLE);
    assign rx_data = shreg_q;
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq_o,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        eng_active,
    input  logic        eng_held,
    input  logic        eng_done,
    input  logic        eng_ack_ok,
    input  logic [7:0]  eng_rx,
    output logic        eng_go,
    output logic        eng_abort,
    output byte_cmd_t   eng_cmd
);
    logic [15:0] ctl_q, sts_q, sts_nx;
    logic [7:0]  dbuf_q;
    logic [6:0]  own_q;
    logic        rcv_q;
    logic        ctl_wr, sts_wr;

    assign ctl_wr    = reg_wr && (reg_addr == OFS_CTL) && !eng_active;
    assign sts_wr    = reg_wr && (reg_addr == OFS_STS);
    assign eng_go    = ctl_wr && reg_wdata[C_XFER] && reg_wdata[C_EN];
    assign eng_abort = ctl_wr && !reg_wdata[C_XFER] && reg_wdata[C_EN] && reg_wdata[C_ABORT];

    always_comb begin
        eng_cmd.start   = reg_wdata[C_START];
        eng_cmd.stop    = reg_wdata[C_STOP];
        eng_cmd.nack    = reg_wdata[C_NACK];
        eng_cmd.rx      = !reg_wdata[C_START] && sts_q[S_RW];
        eng_cmd.tx_byte = dbuf_q;
    end

    always_comb begin
        sts_nx = sts_q;
        if (sts_wr) sts_nx = sts_nx & ~(reg_wdata & STS_W1C);
        if (eng_go && reg_wdata[C_START]) sts_nx[S_RW] = dbuf_q[0];
        if (eng_done) begin
            if (eng_ack_ok) begin
                if (rcv_q) sts_nx[S_RF] = 1'b1;
                else       sts_nx[S_TE] = 1'b1;
                sts_nx[S_ACK] = 1'b0;
            end else begin
                sts_nx[S_TE]  = 1'b1;
                sts_nx[S_BE]  = 1'b1;
                sts_nx[S_ACK] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            sts_q  <= '0;
            dbuf_q <= '0;
            own_q  <= '0;
            rcv_q  <= 1'b0;
        end else begin
            sts_q <= sts_nx;
            if (ctl_wr) ctl_q <= reg_wdata & CTL_KEEP;
            if (eng_go) rcv_q <= eng_cmd.rx;
            if (reg_wr && reg_addr == OFS_OWN) own_q <= reg_wdata[6:0];
            if (reg_wr && reg_addr == OFS_BUF) dbuf_q <= reg_wdata[7:0];
            if (eng_done && eng_ack_ok && rcv_q) dbuf_q <= eng_rx;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_MON: reg_rdata = {14'd0, scl_i, sda_i};
            OFS_BUF: reg_rdata = {8'd0, dbuf_q};
            OFS_CTL: reg_rdata = ctl_q;
            OFS_STS: reg_rdata = sts_q | {13'd0, eng_held, 2'd0};
            OFS_OWN: reg_rdata = {9'd0, own_q};
            default: reg_rdata = 16'd0;
        endcase
    end

    assign irq_o = (sts_q[S_BE] && ctl_q[C_BEIE]) ||
                   (sts_q[S_RF] && ctl_q[C_RFIE]) ||
                   (sts_q[S_TE] && ctl_q[C_TEIE]) ||
                   sts_q[S_SLV];
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int unsigned HALF_PERIOD = 625
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq_o,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe
);
    logic       eng_go, eng_abort, eng_active, eng_held, eng_done, eng_ack_ok;
    logic [7:0] eng_rx;
    byte_cmd_t  eng_cmd;

    i2cm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .eng_active(eng_active),
        .eng_held  (eng_held),
        .eng_done  (eng_done),
        .eng_ack_ok(eng_ack_ok),
        .eng_rx    (eng_rx),
        .eng_go    (eng_go),
        .eng_abort (eng_abort),
        .eng_cmd   (eng_cmd)
    );

    i2cm_engine #(.HALF_PERIOD(HALF_PERIOD)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (eng_go),
        .cmd    (eng_cmd),
        .abort  (eng_abort),
        .sda_i  (sda_i),
        .scl_low(scl_oe),
        .sda_low(sda_oe),
        .active (eng_active),
        .held   (eng_held),
        .done   (eng_done),
        .ack_ok (eng_ack_ok),
        .rx_data(eng_rx)
    );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [7:0]  reg_addr,
    input logic [15:0] reg_rdata,
    input logic        irq_o,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        eng_active,
    input logic        eng_held,
    input logic        eng_done
);
    AST_CTL_XFER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CTL) |-> !reg_rdata[C_XFER]); // R2

    AST_BUF_EIGHT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_BUF) |-> (reg_rdata[15:8] == 8'd0)); // R11

    AST_OWN_SEVEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_OWN) |-> (reg_rdata[15:7] == 9'd0)); // R11

    AST_FLAG_ONLY_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STS && $past(reg_addr) == OFS_STS &&
         reg_rdata[S_TE] && !$past(reg_rdata[S_TE])) |-> $past(eng_done)); // R6

    AST_NACK_SETS_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STS && $past(reg_addr) == OFS_STS &&
         reg_rdata[S_ACK] && !$past(reg_rdata[S_ACK])) |-> (reg_rdata[S_BE] && reg_rdata[S_TE])); // R7

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(eng_done) || $past(reg_wr && reg_addr == OFS_CTL))); // R9

    AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_held && !eng_active && $past(!eng_held && !eng_active)) |-> (!scl_oe && !sda_oe)); // R5
endmodule

bind i2c_byte_master i2cm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .eng_active(eng_active),
    .eng_held  (eng_held),
    .eng_done  (eng_done)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
    localparam logic [7:0] A_MON = 8'h80, A_BUF = 8'h88, A_CTL = 8'h90, A_STS = 8'h98, A_OWN = 8'hA0;
    localparam logic [6:0] TGT = 7'h3A;
    localparam int NV = 9;
    // {buffer byte, control word, expected status, expected byte on bus / buffer}
    localparam logic [47:0] VEC [NV] = '{
        {8'h74, 16'h0049, 16'h0044, 8'h74},
        {8'h5C, 16'h0048, 16'h0044, 8'h5C},
        {8'hFF, 16'h0048, 16'h0446, 8'hFF},
        {8'h75, 16'h0049, 16'h0045, 8'h75},
        {8'h00, 16'h0048, 16'h0085, 8'hA5},
        {8'h00, 16'h004E, 16'h0081, 8'hA6},
        {8'h74, 16'h0049, 16'h0044, 8'h74},
        {8'h00, 16'h004A, 16'h0040, 8'h00},
        {8'h20, 16'h0049, 16'h0446, 8'h20}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000, reg_rdata;
    logic irq_o, scl_oe, sda_oe, bus_scl, bus_sda;
    logic t_low = 1'b0;
    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign bus_scl = ~scl_oe;
    assign bus_sda = ~(sda_oe | t_low);

    i2c_byte_master #(.HALF_PERIOD(4)) u_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .scl_i(bus_scl), .sda_i(bus_sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // behavioural target at address TGT
    int cnt = 0, starts = 0, stops = 0;
    logic act = 0, rd_mode = 0, matched = 0, addr_ph = 0, quiet = 0;
    logic [7:0] sh = 0, outb = 0, last = 0;

    always @(negedge bus_sda) if (bus_scl) begin
        starts++; act = 1; cnt = 0; addr_ph = 1; rd_mode = 0; quiet = 0; t_low = 0;
    end
    always @(posedge bus_sda) if (bus_scl && act) begin
        stops++; act = 0; t_low = 0;
    end
    always @(posedge bus_scl) if (act) begin
        if (cnt >= 1 && cnt <= 8) begin
            sh = {sh[6:0], bus_sda};
            if (cnt == 8) last = sh;
        end else if (cnt == 9 && rd_mode && !addr_ph && bus_sda) begin
            quiet = 1;
        end
    end
    always @(negedge bus_scl) if (act) begin
        cnt = cnt + 1;
        if (cnt == 9) begin
            if (addr_ph)       t_low = (sh[7:1] == TGT);
            else if (!rd_mode) t_low = matched && (sh != 8'hFF);
            else               t_low = 0;
        end else if (cnt == 10) begin
            t_low = 0; cnt = 1;
            if (addr_ph) begin
                addr_ph = 0; matched = (sh[7:1] == TGT); rd_mode = sh[0]; outb = 8'hA5;
            end else if (rd_mode && !quiet) begin
                outb = outb + 1;
            end
        end
        if (cnt >= 1 && cnt <= 8 && rd_mode && matched && !quiet) t_low = ~outb[8-cnt];
    end

    task automatic chk(input string tag, input logic [15:0] a, input logic [15:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_flag();
        logic [15:0] s;
        for (int k = 0; k < 3000; k++) begin
            rd(A_STS, s);
            if (s[6] | s[7]) break;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0, 6:    return "R3 R6 address write";
            1:       return "R4 R6 transmit byte";
            2:       return "R7 data nack";
            3:       return "R3 R6 repeated start read";
            4:       return "R4 R6 receive with ack";
            5:       return "R4 R5 receive nack then stop";
            7:       return "R5 R6 transmit then stop";
            default: return "R7 address nack";
        endcase
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        wait (cyc >= 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        logic [15:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        rd(A_CTL, v); chk("R13 reset control", v, 16'h0000);
        rd(A_STS, v); chk("R13 reset status", v, 16'h0000);
        chk("R13 reset irq", {15'd0, irq_o}, 16'h0000);
        rd(A_MON, v); chk("R13 lines released", v, 16'h0003);
        wr(A_BUF, 16'h1234); rd(A_BUF, v); chk("R11 buffer width", v, 16'h0034);
        wr(A_OWN, 16'h00FF); rd(A_OWN, v); chk("R11 own address width", v, 16'h007F);
        rd(8'h84, v); chk("R1 unmapped offset", v, 16'h0000);
        rd(8'hA8, v); chk("R1 unmapped offset high", v, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] e;
            e = VEC[i];
            wr(A_BUF, {8'h00, e[47:40]});
            wr(A_CTL, e[39:24]);
            wait_flag();
            rd(A_STS, v); chk(vec_tag(i), v, e[23:8]);
            rd(A_BUF, v); chk(vec_tag(i), v, {8'h00, e[7:0]});
            chk(vec_tag(i), {8'h00, last}, {8'h00, e[7:0]});
            wr(A_STS, 16'h07F0);
        end
        rd(A_CTL, v); chk("R2 transfer bit not stored", v, 16'h0041);
        chk("R3 start conditions seen", 16'(starts), 16'd4);
        chk("R5 stop conditions seen", 16'(stops), 16'd2);

        wr(A_CTL, 16'h0050);
        idle(60);
        rd(A_STS, v); chk("R10 abort releases busy", v, 16'h0002);
        chk("R10 abort stop on bus", 16'(stops), 16'd3);
        rd(A_MON, v); chk("R13 monitor after stop", v, 16'h0003);

        wr(A_BUF, 16'h0074);
        wr(A_CTL, 16'h0049);
        idle(10);
        wr(A_CTL, 16'h004A);
        wait_flag();
        rd(A_STS, v); chk("R12 write during byte ignored", v, 16'h0044);
        rd(A_CTL, v); chk("R12 control unchanged", v, 16'h0041);
        chk("R12 no stop taken", 16'(stops), 16'd3);

        @(negedge clk); #1; chk("R9 irq masked", {15'd0, irq_o}, 16'h0000);
        wr(A_CTL, 16'h0140); #1; chk("R9 irq transmit-empty enabled", {15'd0, irq_o}, 16'h0001);
        wr(A_CTL, 16'h0640); #1; chk("R9 irq other enables only", {15'd0, irq_o}, 16'h0000);
        wr(A_CTL, 16'h0140);
        wr(A_STS, 16'h000F);
        rd(A_STS, v); chk("R8 low bits not cleared", v, 16'h0044);
        wr(A_STS, 16'h07F0);
        rd(A_STS, v); chk("R8 flags cleared", v, 16'h0004);
        #1; chk("R9 irq drops after clear", {15'd0, irq_o}, 16'h0000);

        wr(A_BUF, 16'h00FF);
        wr(A_CTL, 16'h0448);
        wait_flag();
        #1; chk("R9 irq bus-error enabled", {15'd0, irq_o}, 16'h0001);
        rd(A_STS, v); chk("R7 nack with bus error", v, 16'h0446);

        wr(A_CTL, 16'h0050);
        idle(60);
        rd(A_STS, v); chk("R10 second abort", v, 16'h0442);
        summary();
    end
endmodule